// File: doc/BRIEF.md
# Single Pulse Former

This block turns each rising edge of a binary input into one output pulse. The pulse has a fixed length that software or a neighbouring block sets. The length is counted in ticks of a time-base enable that is shared across the chip, so one clock domain can serve millisecond-scale timing without wide prescalers in every user. The pulse length does not depend on how long the input stays high. A one-tick input still gives a full pulse, and an input held high for a long time gives only one pulse.

The input is looked at only on tick cycles. An edge is a tick on which the input is high and was low at the previous tick. The output goes high on the same tick edge that sees the qualifying edge. It then stays high for the programmed number of ticks and drops without waiting for the input. The length is captured when the pulse starts, so changing it mid-pulse has no effect on that pulse. After reset the block treats the input as though it had been high, so an input that is already high when reset is released does not count as an edge.

Top module: `single_pulse_former`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `q` is 0. An input already high when reset is released gives no pulse until it has gone low on a tick and risen on a later tick.
- R2: On a clock edge where `tick` is 1, `set_in` is 1, `set_in` was 0 at the previous tick, no pulse is active and `pulse_len` is nonzero, `q` becomes 1 at that same edge.
- R3: A started pulse keeps `q` at 1 for exactly `pulse_len` ticks, counting the starting tick, and `q` returns to 0 at the next tick edge.
- R4: If `set_in` stays high longer than the pulse, `q` still falls on time, and no further pulse starts until `set_in` has been sampled low and then high again.
- R5: A `set_in` that is high for a single tick still gives a pulse of the full programmed length.
- R6: A rising edge seen while a pulse is active, including on its final tick, is ignored and does not restart or lengthen the pulse.
- R7: A rising edge with `pulse_len` equal to 0 gives no pulse.
- R8: `pulse_len` (16-bit unsigned) is sampled only at the start of a pulse. Changes during the pulse do not alter its length.
- R9: `set_in` and `q` change state only on tick cycles. A `set_in` excursion that begins and ends between ticks has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Time-base enable, one clock cycle wide per tick |
| set_in | input | 1 | Binary trigger input, synchronous to `clk` |
| pulse_len | input | 16 | Pulse length in ticks, 0 disables triggering |
| q | output | 1 | Registered pulse output |

## Verification
The assertions assume that `set_in` and `pulse_len` are already synchronous to `clk` and stable around the clock edge. They also assume that `tick` is a single-cycle strobe and not held high for long runs; a run of high cycles is still legal, but each high cycle then counts as a tick. The stimulus keeps within these assumptions. It changes inputs only on falling clock edges and raises `tick` for exactly one cycle per step, with at least one idle cycle between steps. The only exception is the short between-tick pulses on `set_in` that are applied on purpose to show they are ignored.

// File: rtl/sp_pkg.sv
package sp_pkg;
  typedef enum logic {
    SP_IDLE   = 1'b0,
    SP_ACTIVE = 1'b1
  } sp_state_e;
endpackage

// File: rtl/sp_edge_qual.sv
// Tick-qualified rising edge detector; history resets to PREV_INIT.
module sp_edge_qual #(
  parameter logic PREV_INIT = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic sig,
  output logic rise
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= PREV_INIT;
    end else if (tick) begin
      prev_q <= sig;
    end
  end

  assign rise = tick & sig & ~prev_q;
endmodule

// File: rtl/sp_dur_counter.sv
// Down counter holding ticks still to run after the current one.
module sp_dur_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         expired
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (dec) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/sp_pulse_fsm.sv
module sp_pulse_fsm
  import sp_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         rise,
  input  logic [W-1:0] len,
  input  logic         expired,
  output logic         load,
  output logic [W-1:0] load_val,
  output logic         dec,
  output logic         q
);
  sp_state_e state_q;
  logic      start;
  logic      finish;

  always_comb begin
    start    = (state_q == SP_IDLE) && rise && (len != '0);
    finish   = (state_q == SP_ACTIVE) && tick && expired;
    load     = start;
    load_val = len - 1'b1;
    dec      = (state_q == SP_ACTIVE) && tick && !expired;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SP_IDLE;
      q       <= 1'b0;
    end else begin
      unique case (state_q)
        SP_IDLE: begin
          if (start) begin
            state_q <= SP_ACTIVE;
            q       <= 1'b1;
          end
        end
        SP_ACTIVE: begin
          if (finish) begin
            state_q <= SP_IDLE;
            q       <= 1'b0;
          end
        end
        default: begin
          state_q <= SP_IDLE;
          q       <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/single_pulse_former.sv
module single_pulse_former #(
  parameter int   LEN_W     = 16,
  parameter logic PREV_INIT = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             set_in,
  input  logic [LEN_W-1:0] pulse_len,
  output logic             q
);
  logic             rise;
  logic             load;
  logic [LEN_W-1:0] load_val;
  logic             dec;
  logic             expired;

  sp_edge_qual #(.PREV_INIT(PREV_INIT)) u_edge (
    .clk (clk),
    .rst (rst),
    .tick(tick),
    .sig (set_in),
    .rise(rise)
  );

  sp_dur_counter #(.W(LEN_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .load_val(load_val),
    .dec     (dec),
    .expired (expired)
  );

  sp_pulse_fsm #(.W(LEN_W)) u_fsm (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .rise    (rise),
    .len     (pulse_len),
    .expired (expired),
    .load    (load),
    .load_val(load_val),
    .dec     (dec),
    .q       (q)
  );
endmodule

// File: rtl/sp_checker.sv
module sp_checker #(
  parameter int LEN_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             tick,
  input logic             set_in,
  input logic [LEN_W-1:0] pulse_len,
  input logic             q
);
  logic             q_d;
  logic [LEN_W-1:0] len_d;
  logic [LEN_W-1:0] len_lat;
  logic [LEN_W:0]   hi_ticks;

  always_ff @(posedge clk) begin
    if (rst) begin
      q_d      <= 1'b0;
      len_d    <= '0;
      len_lat  <= '0;
      hi_ticks <= '0;
    end else begin
      q_d   <= q;
      len_d <= pulse_len;
      if (q && !q_d) len_lat <= len_d;
      if (!q) hi_ticks <= '0;
      else if (tick) hi_ticks <= hi_ticks + 1'b1;
    end
  end

  // R1
  a_r1_reset_low: assert property (@(posedge clk) rst |=> !q);

  // R2: a pulse starts only on a tick with the input high
  a_r2_start_on_high_tick: assert property (@(posedge clk) disable iff (rst)
    $rose(q) |-> ($past(tick) && $past(set_in)));

  // R7
  a_r7_zero_len_no_pulse: assert property (@(posedge clk) disable iff (rst)
    $rose(q) |-> ($past(pulse_len) != '0));

  // R9
  a_r9_change_on_tick: assert property (@(posedge clk) disable iff (rst)
    !$stable(q) |-> $past(tick));

  // R3 and R8: high-tick count equals the length captured at the start
  a_r3_width_matches: assert property (@(posedge clk) disable iff (rst)
    (q_d && !q) |-> (hi_ticks == {1'b0, len_lat}));
endmodule

bind single_pulse_former sp_checker #(.LEN_W(LEN_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .tick     (tick),
  .set_in   (set_in),
  .pulse_len(pulse_len),
  .q        (q)
);

// File: tb/sim_single_pulse_former.sv
`timescale 1ns/1ps
module sim_single_pulse_former;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        set_in = 1'b0;
  logic [15:0] pulse_len = 16'd0;
  logic        q;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  typedef struct {
    logic  exp;
    string tag;
  } item_t;
  item_t sb[$];

  // reference state, from the requirements
  logic ref_prev = 1'b1;
  int   ref_left = 0;

  always #2.5 clk = ~clk;

  single_pulse_former u0 (
    .clk(clk), .rst(rst), .tick(tick), .set_in(set_in),
    .pulse_len(pulse_len), .q(q)
  );

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: q actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  // one tick step followed by one idle cycle; pushes expected q
  task automatic step(input logic s, input logic [15:0] len, input string tag);
    item_t it;
    @(negedge clk);
    set_in    = s;
    pulse_len = len;
    tick      = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    if (ref_left > 0) ref_left = ref_left - 1;
    else if (s && !ref_prev && len != 0) ref_left = int'(len);
    ref_prev = s;
    it.exp = (ref_left > 0);
    it.tag = tag;
    sb.push_back(it);
    @(negedge clk);
  endtask

  // monitor: pops each expected item as soon as it is produced
  initial begin
    forever begin
      item_t it;
      wait (sb.size() > 0);
      it = sb.pop_front();
      chk(q, it.exp, it.tag);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: input high through reset release
    set_in    = 1'b1;
    pulse_len = 16'd3;
    repeat (3) @(negedge clk);
    chk(q, 1'b0, "R1 during reset");
    rst = 1'b0;
    @(negedge clk);
    chk(q, 1'b0, "R1 after release");
    step(1, 3, "R1 high at release");
    step(1, 3, "R1 still high");
    step(0, 3, "R1 low");

    // R2/R3/R4: long input, 3-tick pulse
    step(1, 3, "R2 start same tick");
    step(1, 3, "R3 width tick2");
    step(1, 3, "R3 width tick3");
    step(1, 3, "R4 drop while high");
    for (int i = 0; i < 4; i++) step(1, 3, "R4 no second pulse");
    step(0, 3, "R4 low");
    step(1, 3, "R4 re-arm after low");
    for (int i = 0; i < 3; i++) step(1, 3, "R3 re-armed pulse");

    // R5: one-tick input
    step(0, 3, "R5 low");
    step(1, 3, "R5 one tick");
    for (int i = 0; i < 4; i++) step(0, 3, "R5 full length");

    // R6: edges during active pulse, including the last tick
    step(1, 5, "R6 start");
    step(0, 5, "R6 low mid");
    step(1, 5, "R6 edge ignored");
    step(0, 5, "R6 low");
    step(1, 5, "R6 edge on final tick");
    for (int i = 0; i < 3; i++) step(0, 5, "R6 no restart");

    // R7: zero length
    step(1, 0, "R7 zero length");
    step(1, 0, "R7 held");
    step(0, 0, "R7 low");

    // R8: length changed mid-pulse
    step(1, 4, "R8 start len4");
    for (int i = 0; i < 5; i++) step(0, 1, "R8 len change ignored");
    step(1, 16'd1, "R3 length one");
    step(0, 16'd1, "R3 length one end");

    // R9: between-tick excursion ignored
    @(negedge clk); set_in = 1'b1;
    @(negedge clk); set_in = 1'b0;
    @(negedge clk);
    chk(q, 1'b0, "R9 no pulse between ticks");
    step(0, 3, "R9 no edge seen");
    step(0, 3, "R9 still idle");

    // R3: longer length
    step(1, 16'd40, "R3 long start");
    for (int i = 0; i < 41; i++) step(0, 16'd40, "R3 long pulse");

    wait (sb.size() == 0);
    @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule